// File: doc/BRIEF.md
# I2C Master Start and Address Sequencer

This block runs the opening of every I2C master transfer: it issues the Start or repeated Start condition and shifts out the slave address. It also keeps the event flags through which software steps the sequence forward. Software asks for a Start with a one-cycle request pulse. From then on, each step waits for a fixed handshake. A strobe marks a read of the event-status register, and another strobe marks either a data-register write or a read of the mode-status register. The block leaves the bus, with SCL held low, once the address has been acknowledged and software has cleared the address-sent flag.

Two address forms are supported. In 7-bit mode, software writes one byte, and its least significant bit sets the direction. In 10-bit mode, software first writes a header byte of the form 11110 followed by two address bits and a 0, then the low address byte. For a 10-bit read, software next asks for a repeated Start and writes the header again with its last bit set. That header ends the address phase directly.

The states are: `ST_IDLE` (lines released), `ST_RS_LO` and `ST_RS_HI` (SDA released with SCL low, then SCL raised, before a repeated Start), `ST_STA_HOLD` (SDA low while SCL high), `ST_STA_LO` (SCL pulled low), `ST_WAIT_SB`, `ST_SHIFT` (nine SCL periods per byte), `ST_WAIT_HDR`, `ST_WAIT_ADDR` and `ST_HANDOFF`. The transitions are as follows.
- A pending request with the bus free moves IDLE to STA_HOLD.
- Each quarter-period tick steps RS_LO to RS_HI to STA_HOLD to STA_LO to WAIT_SB.
- The start-sent clear moves WAIT_SB to SHIFT, and the header-sent clear moves WAIT_HDR to SHIFT.
- At the end of a byte, SHIFT moves to WAIT_HDR or WAIT_ADDR.
- The address-sent clear moves WAIT_ADDR to HANDOFF.
- A pending request in any wait state or in HANDOFF moves to RS_LO.

Top module: `i2c_addr_seq`

## Requirements
- R1: A Start request produces a Start only while `bus_busy` is low, and `mode_master` goes high with that Start. The request stays pending while the bus is busy. Before any Start, `scl_o` and `sda_o` are both 1.
- R2: A Start is a falling edge of SDA while SCL is high, and SCL then stays high for at least `QTR` clock cycles. SDA never rises while SCL stays high.
- R3: `flag_sb` is set after each Start (and each repeated Start) has been driven. `ev_irq` is high exactly when `ev_int_en` is 1 and at least one of `flag_sb`, `flag_hdr` and `flag_addr` is 1.
- R4: `flag_sb` clears only when a `dr_wr` follows a `sr1_rd` made after the flag was set. That write loads the byte to send. A `dr_wr` without such a prior read leaves the flag set and sends nothing.
- R5: A byte is sent MSB first, one bit per SCL period, followed by a ninth clock with SDA released. `ack_ok` becomes 1 if `sda_i` is 0 on that ninth clock, and 0 if it is 1.
- R6: In 7-bit mode (`ten_bit`=0), one byte is sent, then `flag_addr` is set. `mode_tx` is 1 when the byte's bit 0 was 0, and 0 when it was 1.
- R7: In 10-bit mode, the first byte after the first Start sets `flag_hdr` and not `flag_addr`, with `mode_tx`=1 for a header whose bit 0 is 0. A `sr1_rd` followed by a `dr_wr` clears `flag_hdr` and sends the written byte, and `flag_addr` is then set.
- R8: `flag_addr` clears only when a `sr2_rd` follows a `sr1_rd` made after the flag was set. A `sr2_rd` alone leaves it set.
- R9: A Start request in master mode produces a repeated Start. If a byte is being shifted, that Start waits until the byte and its acknowledge clock have finished.
- R10: In 10-bit mode, once a full address has been sent, the byte after a repeated Start ends the address phase. It sets `flag_addr` and not `flag_hdr`, and `mode_tx` is taken from its bit 0 (0 for a header ending in 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | One-cycle pulse requesting a Start or repeated Start |
| bus_busy | input | 1 | Another master holds the bus |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| ev_int_en | input | 1 | Event interrupt enable |
| sr1_rd | input | 1 | Strobe: event-status register read |
| sr2_rd | input | 1 | Strobe: mode-status register read |
| dr_wr | input | 1 | Strobe: data-register write |
| dr_wdata | input | 8 | Byte written with `dr_wr` |
| sda_i | input | 1 | Sampled SDA line |
| scl_o | output | 1 | SCL drive, 1 releases |
| sda_o | output | 1 | SDA drive, 1 releases |
| flag_sb | output | 1 | Start-sent flag |
| flag_hdr | output | 1 | 10-bit header-sent flag |
| flag_addr | output | 1 | Address-sent flag |
| mode_master | output | 1 | Master mode |
| mode_tx | output | 1 | 1 transmitter, 0 receiver |
| ack_ok | output | 1 | Last ninth-clock sample was an acknowledge |
| ev_irq | output | 1 | Event interrupt |

## Verification
The bench targets the handshake order. It issues a data write or a mode-status read with no prior event-status read. A design that skipped the read-first rule would clear the flag early and start shifting a byte nobody armed. It also requests a restart while an address byte is still shifting, and counts bytes on the wire before the second Start. A design that honoured the request at once would truncate the byte. The 10-bit read path checks that the resent header ends the address phase. A design that treated every 10-bit header alike would raise the header flag again and stall. A bus monitor checks Start shape and bit order, including the hold time of SDA low before SCL falls.

// File: rtl/i2c_as_pkg.sv
package i2c_as_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RS_LO,
        ST_RS_HI,
        ST_STA_HOLD,
        ST_STA_LO,
        ST_WAIT_SB,
        ST_SHIFT,
        ST_WAIT_HDR,
        ST_WAIT_ADDR,
        ST_HANDOFF
    } seq_state_e;

    localparam int FLAG_SB  = 0;
    localparam int FLAG_HDR = 1;
    localparam int FLAG_ADR = 2;
    localparam int NFLAGS   = 3;

endpackage

// File: rtl/i2c_as_qtick.sv
module i2c_as_qtick #(
    parameter int QTR = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(QTR - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_as_flag.sv
module i2c_as_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic first_i,
    input  logic second_i,
    output logic flag_o,
    output logic clr_o
);
    logic armed;

    assign clr_o = flag_o && armed && second_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            armed  <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
            armed  <= 1'b0;
        end else if (clr_o) begin
            flag_o <= 1'b0;
            armed  <= 1'b0;
        end else if (first_i && flag_o) begin
            armed  <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_as_fsm.sv
module i2c_as_fsm
    import i2c_as_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic            run,
    input  logic            start_req,
    input  logic            bus_busy,
    input  logic            ten_bit,
    input  logic            sda_i,
    input  logic [BITS-1:0] dr_wdata,
    input  logic            clr_sb,
    input  logic            clr_hdr,
    input  logic            clr_adr,
    output logic            set_sb,
    output logic            set_hdr,
    output logic            set_adr,
    output logic            scl_o,
    output logic            sda_o,
    output logic            master,
    output logic            tra,
    output logic            ack_ok
);
    localparam int BW = $clog2(BITS + 1);

    seq_state_e      state, nxt;
    logic            pend;
    logic [BITS-1:0] shreg;
    logic            lsb;
    logic [BW-1:0]   bidx;
    logic [1:0]      q;
    logic            kind_hdr;
    logic            ten_done;
    logic            byte_end;
    logic            load;
    logic            go_start;
    logic            go_rs;

    assign byte_end = (state == ST_SHIFT) && tick && (q == 2'd3) && (bidx == BW'(BITS));
    assign load     = ((state == ST_WAIT_SB) && clr_sb) || ((state == ST_WAIT_HDR) && clr_hdr);
    assign go_start = (state == ST_IDLE) && (nxt == ST_STA_HOLD);
    assign go_rs    = (state != ST_RS_LO) && (nxt == ST_RS_LO);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (pend && !bus_busy) nxt = ST_STA_HOLD;
            ST_RS_LO:     if (tick) nxt = ST_RS_HI;
            ST_RS_HI:     if (tick) nxt = ST_STA_HOLD;
            ST_STA_HOLD:  if (tick) nxt = ST_STA_LO;
            ST_STA_LO:    if (tick) nxt = ST_WAIT_SB;
            ST_WAIT_SB: begin
                if (clr_sb)    nxt = ST_SHIFT;
                else if (pend) nxt = ST_RS_LO;
            end
            ST_SHIFT:     if (byte_end) nxt = kind_hdr ? ST_WAIT_HDR : ST_WAIT_ADDR;
            ST_WAIT_HDR: begin
                if (clr_hdr)   nxt = ST_SHIFT;
                else if (pend) nxt = ST_RS_LO;
            end
            ST_WAIT_ADDR: begin
                if (pend)         nxt = ST_RS_LO;
                else if (clr_adr) nxt = ST_HANDOFF;
            end
            ST_HANDOFF:   if (pend) nxt = ST_RS_LO;
            default:      nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            master   <= 1'b0;
            tra      <= 1'b0;
            ack_ok   <= 1'b0;
            shreg    <= '0;
            lsb      <= 1'b0;
            bidx     <= '0;
            q        <= '0;
            kind_hdr <= 1'b0;
            ten_done <= 1'b0;
        end else begin
            if (start_req)              pend <= 1'b1;
            else if (go_start || go_rs) pend <= 1'b0;
            if (go_start) master <= 1'b1;
            if (load) begin
                shreg    <= dr_wdata;
                lsb      <= dr_wdata[0];
                bidx     <= '0;
                q        <= '0;
                kind_hdr <= (state == ST_WAIT_SB) && ten_bit && !ten_done;
                if (state == ST_WAIT_HDR) ten_done <= 1'b1;
            end else if ((state == ST_SHIFT) && tick) begin
                q <= q + 2'd1;
                if ((q == 2'd2) && (bidx == BW'(BITS))) ack_ok <= !sda_i;
                if (q == 2'd3) begin
                    shreg <= {shreg[BITS-2:0], 1'b0};
                    bidx  <= bidx + 1'b1;
                end
            end
            if (byte_end) tra <= !lsb;
        end
    end

    assign set_sb  = (state == ST_STA_LO) && tick;
    assign set_hdr = byte_end && kind_hdr;
    assign set_adr = byte_end && !kind_hdr;

    // line outputs
    always_comb begin
        run   = 1'b0;
        scl_o = 1'b0;
        sda_o = 1'b1;
        unique case (state)
            ST_IDLE:     begin scl_o = 1'b1; sda_o = 1'b1; end
            ST_RS_LO:    begin run = 1'b1; scl_o = 1'b0; sda_o = 1'b1; end
            ST_RS_HI:    begin run = 1'b1; scl_o = 1'b1; sda_o = 1'b1; end
            ST_STA_HOLD: begin run = 1'b1; scl_o = 1'b1; sda_o = 1'b0; end
            ST_STA_LO:   begin run = 1'b1; scl_o = 1'b0; sda_o = 1'b0; end
            ST_SHIFT: begin
                run   = 1'b1;
                scl_o = q[1];
                sda_o = (bidx == BW'(BITS)) ? 1'b1 : shreg[BITS-1];
            end
            ST_WAIT_SB, ST_WAIT_HDR, ST_WAIT_ADDR, ST_HANDOFF: begin
                scl_o = 1'b0;
                sda_o = 1'b1;
            end
            default: begin scl_o = 1'b1; sda_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
    import i2c_as_pkg::*;
#(
    parameter int QTR  = 4,
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_req,
    input  logic            bus_busy,
    input  logic            ten_bit,
    input  logic            ev_int_en,
    input  logic            sr1_rd,
    input  logic            sr2_rd,
    input  logic            dr_wr,
    input  logic [BITS-1:0] dr_wdata,
    input  logic            sda_i,
    output logic            scl_o,
    output logic            sda_o,
    output logic            flag_sb,
    output logic            flag_hdr,
    output logic            flag_addr,
    output logic            mode_master,
    output logic            mode_tx,
    output logic            ack_ok,
    output logic            ev_irq
);
    logic              tick;
    logic              run;
    logic [NFLAGS-1:0] set_v;
    logic [NFLAGS-1:0] sec_v;
    logic [NFLAGS-1:0] flag_v;
    logic [NFLAGS-1:0] clr_v;

    i2c_as_qtick #(.QTR(QTR)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    assign sec_v[FLAG_SB]  = dr_wr;
    assign sec_v[FLAG_HDR] = dr_wr;
    assign sec_v[FLAG_ADR] = sr2_rd;

    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        i2c_as_flag u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_v[g]),
            .first_i  (sr1_rd),
            .second_i (sec_v[g]),
            .flag_o   (flag_v[g]),
            .clr_o    (clr_v[g])
        );
    end

    i2c_as_fsm #(.BITS(BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (run),
        .start_req (start_req),
        .bus_busy  (bus_busy),
        .ten_bit   (ten_bit),
        .sda_i     (sda_i),
        .dr_wdata  (dr_wdata),
        .clr_sb    (clr_v[FLAG_SB]),
        .clr_hdr   (clr_v[FLAG_HDR]),
        .clr_adr   (clr_v[FLAG_ADR]),
        .set_sb    (set_v[FLAG_SB]),
        .set_hdr   (set_v[FLAG_HDR]),
        .set_adr   (set_v[FLAG_ADR]),
        .scl_o     (scl_o),
        .sda_o     (sda_o),
        .master    (mode_master),
        .tra       (mode_tx),
        .ack_ok    (ack_ok)
    );

    assign flag_sb   = flag_v[FLAG_SB];
    assign flag_hdr  = flag_v[FLAG_HDR];
    assign flag_addr = flag_v[FLAG_ADR];
    assign ev_irq    = ev_int_en && (|flag_v);
endmodule

// File: rtl/i2c_addr_seq_chk.sv
module i2c_addr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sr2_rd,
    input logic dr_wr,
    input logic scl_o,
    input logic sda_o,
    input logic flag_sb,
    input logic flag_hdr,
    input logic flag_addr,
    input logic mode_master
);
    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_master |-> (scl_o && sda_o));

    p_master_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_master |=> mode_master);

    p_no_rise_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o)) |-> !$rose(sda_o));

    p_sb_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sb |-> mode_master);

    p_sb_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_sb) |-> $past(dr_wr));

    p_hdr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_hdr) |-> $past(dr_wr));

    p_addr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_addr) |-> $past(sr2_rd));
endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sr2_rd      (sr2_rd),
    .dr_wr       (dr_wr),
    .scl_o       (scl_o),
    .sda_o       (sda_o),
    .flag_sb     (flag_sb),
    .flag_hdr    (flag_hdr),
    .flag_addr   (flag_addr),
    .mode_master (mode_master)
);

// File: tb/i2c_addr_seq_tb.sv
`timescale 1ns/1ps
module i2c_addr_seq_tb;
    localparam int QTR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_req = 1'b0, bus_busy = 1'b0, ten_bit = 1'b0, ev_int_en = 1'b1;
    logic       sr1_rd = 1'b0, sr2_rd = 1'b0, dr_wr = 1'b0;
    logic [7:0] dr_wdata = 8'h00;
    logic       pull_low = 1'b1;
    logic       sda_i;
    logic       scl_o, sda_o, flag_sb, flag_hdr, flag_addr, mode_master, mode_tx, ack_ok, ev_irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    assign sda_i = sda_o & ~pull_low;

    i2c_addr_seq #(.QTR(QTR)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .bus_busy(bus_busy),
        .ten_bit(ten_bit), .ev_int_en(ev_int_en), .sr1_rd(sr1_rd), .sr2_rd(sr2_rd),
        .dr_wr(dr_wr), .dr_wdata(dr_wdata), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o),
        .flag_sb(flag_sb), .flag_hdr(flag_hdr), .flag_addr(flag_addr),
        .mode_master(mode_master), .mode_tx(mode_tx), .ack_ok(ack_ok), .ev_irq(ev_irq)
    );

    // bus monitor
    logic       p_scl, p_sda, in_sta;
    int         starts, nbytes, bitc, hold_cnt, last_hold;
    logic [7:0] shb;
    logic [7:0] seen [0:15];

    always @(negedge clk) begin
        if (!rst_n) begin
            p_scl = 1'b1; p_sda = 1'b1; in_sta = 1'b0;
            starts = 0; nbytes = 0; bitc = 0; hold_cnt = 0; last_hold = 0; shb = 8'h00;
        end else begin
            if (p_scl && scl_o && p_sda && !sda_o) begin
                starts++; bitc = 0; in_sta = 1'b1; hold_cnt = 1;
            end else if (in_sta && scl_o) begin
                hold_cnt++;
            end else if (in_sta && !scl_o) begin
                last_hold = hold_cnt; in_sta = 1'b0;
            end
            if (!p_scl && scl_o) begin
                if (bitc < 8) shb = {shb[6:0], sda_o};
                bitc++;
                if (bitc == 8 && nbytes < 16) begin seen[nbytes] = shb; nbytes++; end
                if (bitc == 9) bitc = 0;
            end
            p_scl = scl_o; p_sda = sda_o;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        start_req = 0; sr1_rd = 0; sr2_rd = 0; dr_wr = 0; bus_busy = 0; ten_bit = 0;
        ev_int_en = 1; pull_low = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic p_start(); @(negedge clk); start_req = 1; @(negedge clk); start_req = 0; endtask
    task automatic p_sr1();   @(negedge clk); sr1_rd = 1;    @(negedge clk); sr1_rd = 0;    endtask
    task automatic p_sr2();   @(negedge clk); sr2_rd = 1;    @(negedge clk); sr2_rd = 0;    endtask
    task automatic p_dr(input logic [7:0] b);
        @(negedge clk); dr_wdata = b; dr_wr = 1; @(negedge clk); dr_wr = 0;
    endtask

    function automatic bit flag_of(input int i);
        case (i)
            0: return flag_sb;
            1: return flag_hdr;
            default: return flag_addr;
        endcase
    endfunction

    task automatic wait_flag(input int i, input string req);
        bit hit = 0;
        for (int n = 0; n < 2000 && !hit; n++) begin
            @(negedge clk);
            hit = flag_of(i);
        end
        check(hit, req, "flag wait timeout", 0, 1);
    endtask

    task automatic t_reset();
        do_reset();
        check(scl_o && sda_o, "R1", "idle lines", {scl_o, sda_o}, 2'b11);
        check(!mode_master && !flag_sb && !flag_hdr && !flag_addr, "R1", "reset flags",
              {mode_master, flag_sb, flag_hdr, flag_addr}, 0);
        check(!ev_irq, "R3", "reset irq", ev_irq, 0);
    endtask

    task automatic t_busy_start();
        do_reset();
        bus_busy = 1;
        p_start();
        repeat (60) @(negedge clk);
        check(starts == 0 && !mode_master, "R1", "start while busy", starts, 0);
        bus_busy = 0;
        wait_flag(0, "R3");
        check(starts == 1, "R1", "start count", starts, 1);
        check(mode_master, "R1", "master mode", mode_master, 1);
        check(last_hold >= QTR, "R2", "start hold cycles", last_hold, QTR);
        check(ev_irq, "R3", "irq with enable", ev_irq, 1);
    endtask

    task automatic t_tx7();
        do_reset();
        p_start();
        wait_flag(0, "R3");
        p_dr(8'hA4);
        repeat (100) @(negedge clk);
        check(flag_sb, "R4", "sb after lone write", flag_sb, 1);
        check(nbytes == 0, "R4", "bytes sent without read", nbytes, 0);
        p_sr1();
        p_dr(8'hA4);
        check(!flag_sb, "R4", "sb cleared", flag_sb, 0);
        wait_flag(2, "R6");
        check(nbytes == 1 && seen[0] == 8'hA4, "R5", "byte on wire", seen[0], 8'hA4);
        check(mode_tx, "R6", "tx direction", mode_tx, 1);
        check(!flag_hdr, "R6", "no header flag", flag_hdr, 0);
        check(ack_ok, "R5", "ack seen", ack_ok, 1);
        p_sr2();
        repeat (4) @(negedge clk);
        check(flag_addr, "R8", "addr after lone sr2", flag_addr, 1);
        p_sr1();
        p_sr2();
        check(!flag_addr, "R8", "addr cleared", flag_addr, 0);
        check(!ev_irq, "R3", "irq idle", ev_irq, 0);
    endtask

    task automatic t_rx7_nack();
        do_reset();
        ev_int_en = 0;
        pull_low = 0;
        p_start();
        wait_flag(0, "R3");
        check(!ev_irq, "R3", "irq masked", ev_irq, 0);
        p_sr1();
        p_dr(8'h5B);
        wait_flag(2, "R6");
        check(seen[0] == 8'h5B, "R5", "msb first", seen[0], 8'h5B);
        check(!mode_tx, "R6", "rx direction", mode_tx, 0);
        check(!ack_ok, "R5", "nack seen", ack_ok, 0);
    endtask

    task automatic t_ten_bit();
        do_reset();
        ten_bit = 1;
        p_start();
        wait_flag(0, "R3");
        p_sr1();
        p_dr(8'hF2);
        wait_flag(1, "R7");
        check(!flag_addr, "R7", "no addr after header", flag_addr, 0);
        check(mode_tx, "R7", "header tx", mode_tx, 1);
        p_dr(8'h3C);
        repeat (100) @(negedge clk);
        check(flag_hdr && nbytes == 1, "R7", "header flag after lone write", nbytes, 1);
        p_sr1();
        p_dr(8'h3C);
        wait_flag(2, "R7");
        check(nbytes == 2 && seen[1] == 8'h3C, "R7", "second byte", seen[1], 8'h3C);
        p_sr1();
        p_sr2();
        p_start();
        wait_flag(0, "R10");
        check(starts == 2, "R10", "repeated start", starts, 2);
        p_sr1();
        p_dr(8'hF3);
        wait_flag(2, "R10");
        check(!flag_hdr, "R10", "no header flag on resend", flag_hdr, 0);
        check(seen[2] == 8'hF3, "R10", "resent header", seen[2], 8'hF3);
        check(!mode_tx, "R10", "rx after resend", mode_tx, 0);
    endtask

    task automatic t_restart_mid();
        bit hit = 0;
        do_reset();
        p_start();
        wait_flag(0, "R3");
        p_sr1();
        p_dr(8'hC6);
        repeat (20) @(negedge clk);
        p_start();
        for (int n = 0; n < 2000 && !hit; n++) begin
            @(negedge clk);
            hit = (starts == 2);
        end
        check(hit, "R9", "restart seen", starts, 2);
        check(nbytes == 1 && seen[0] == 8'hC6, "R9", "byte finished before restart", nbytes, 1);
        check(flag_addr, "R9", "addr flag kept", flag_addr, 1);
        wait_flag(0, "R9");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_busy_start();
        t_tx7();
        t_rx7_nack();
        t_ten_bit();
        t_restart_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule